// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block holds the interrupt status word of a serial peripheral controller and drives its single interrupt line. It takes the occupancy counts of the transmit and receive FIFOs and derives a set of level flags from them: empty, not-empty, full, and quarter, half and three-quarter marks. Some of these marks are defined on used space and some on free space. It also keeps sticky event bits for overflow, underrun, transfer completion, chip-select activity and a fault bit that software cannot clear.

The surrounding controller feeds it the two counts, one-cycle event pulses, FIFO flush pulses and write-one-to-clear accesses to the status word. It also feeds it the interrupt enable word. The unit returns the current status word and an interrupt level that is high while any enabled status bit is set. Level flags follow the counts in the same cycle. Sticky bits change on the next clock edge.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, with both counts at zero, `status` reads 0x0000_1B00 (bits 8, 9, 11 and 12 set) and `irq` is low while `irq_en` is zero.
- R2: Receive level flags, with D the FIFO depth: bit 0 when rx_used is not 0; bit 3 when rx_used ≥ D/4; bit 1 when rx_used ≥ D/2; bit 4 when free space (D − rx_used) ≤ D/4; bit 2 when rx_used equals D.
- R3: Transmit level flags: bit 8 when tx_used is 0; bit 11 when free space ≥ D/4; bit 9 when free space ≥ D/2; bit 12 when tx_used ≤ D/4; bit 10 when tx_used equals D.
- R4: Level flags follow the counts in the same cycle. A write-one-to-clear access has no effect on them.
- R5: An event pulse sets its sticky bit from the next clock edge on: tx overflow bit 13, tx underrun bit 14, transfer done bit 16, chip-select event bit 17, rx overflow bit 5, rx underrun bit 6, fault bit 31. The bit then holds until it is cleared.
- R6: A write-one-to-clear access clears, from the next edge, each sticky bit whose data bit is one. It leaves every other sticky bit unchanged.
- R7: Bit 31 is never cleared by a write-one-to-clear access. Only reset clears it.
- R8: When an event pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R9: A transmit flush pulse clears bits 13 and 14. A receive flush pulse clears bits 5 and 6. Neither pulse touches the other sticky bits.
- R10: `irq` equals the OR of (status AND irq_en AND 0x0003_7F7F), in the same cycle. Bit 31 and enable bits outside that mask never raise it.
- R11: Status bits 7, 15 and 18 to 30 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_used | input | CW | Entries held in the transmit FIFO (0..DEPTH) |
| rx_used | input | CW | Entries held in the receive FIFO (0..DEPTH) |
| tx_flush | input | 1 | Transmit FIFO flush pulse |
| rx_flush | input | 1 | Receive FIFO flush pulse |
| ev_tx_ovf | input | 1 | Transmit overflow event |
| ev_tx_udf | input | 1 | Transmit underrun event |
| ev_rx_ovf | input | 1 | Receive overflow event |
| ev_rx_udf | input | 1 | Receive underrun event |
| ev_done | input | 1 | Transfer complete event |
| ev_cs | input | 1 | Chip-select event |
| ev_fault | input | 1 | Fault event, clearable only by reset |
| clr_en | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 32 | Write-one-to-clear data |
| irq_en | input | 32 | Interrupt enable word |
| status | output | 32 | Current status word |
| irq | output | 1 | Interrupt level |

## Verification
The counts are driven both with uniform random values and with values at and on each side of the quarter, half and three-quarter marks, and at zero and full. The off-by-one cases separate ≥ from > and separate marks on used space from marks on free space. Random event pulses, clears and flushes, with their overlaps, show whether set-over-clear priority and the per-bit clear masks are correct. Random enable words with bit 31 set show whether the interrupt mask leaks unmasked or unclearable bits.

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_used,
  input  logic [CW-1:0] rx_used,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic          ev_tx_ovf,
  input  logic          ev_tx_udf,
  input  logic          ev_rx_ovf,
  input  logic          ev_rx_udf,
  input  logic          ev_done,
  input  logic          ev_cs,
  input  logic          ev_fault,
  input  logic          clr_en,
  input  logic [31:0]   clr_data,
  input  logic [31:0]   irq_en,
  output logic [31:0]   status,
  output logic          irq
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] QTR_C  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [31:0] CLEARABLE = 32'h0003_6060;
  localparam logic [31:0] TX_STICKY = 32'h0000_6000;
  localparam logic [31:0] RX_STICKY = 32'h0000_0060;
  localparam logic [31:0] IRQ_MASK  = 32'h0003_7F7F;

  logic [CW-1:0] tx_free, rx_free;
  logic [31:0]   lvl, set_v, clr_v, sticky_q;

  assign tx_free = FULL_C - tx_used;
  assign rx_free = FULL_C - rx_used;

  always_comb begin
    lvl     = '0;
    lvl[0]  = rx_used != '0;
    lvl[1]  = rx_used >= HALF_C;
    lvl[2]  = rx_used == FULL_C;
    lvl[3]  = rx_used >= QTR_C;
    lvl[4]  = rx_free <= QTR_C;
    lvl[8]  = tx_used == '0;
    lvl[9]  = tx_free >= HALF_C;
    lvl[10] = tx_used == FULL_C;
    lvl[11] = tx_free >= QTR_C;
    lvl[12] = tx_used <= QTR_C;
  end

  always_comb begin
    set_v     = '0;
    set_v[5]  = ev_rx_ovf;
    set_v[6]  = ev_rx_udf;
    set_v[13] = ev_tx_ovf;
    set_v[14] = ev_tx_udf;
    set_v[16] = ev_done;
    set_v[17] = ev_cs;
    set_v[31] = ev_fault;
  end

  assign clr_v = (clr_en   ? (clr_data & CLEARABLE) : '0)
               | (tx_flush ? TX_STICKY : '0)
               | (rx_flush ? RX_STICKY : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_v) | set_v;

  assign status = sticky_q | lvl;
  assign irq    = |(status & irq_en & IRQ_MASK);

  AST_RESET_VALUE: assert property (@(posedge clk)
    !rst_n && tx_used == '0 && rx_used == '0 |-> status == 32'h0000_1B00); // R1
  AST_RX_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_used == '0) |-> !status[0] && !status[3] && !status[2]); // R2
  AST_TX_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_used == '0) |-> status[8] && status[9] && status[11] && status[12]); // R3
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> status[16]); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && clr_data[17] && !ev_cs |=> !status[17]); // R6
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    status[31] |=> status[31]); // R7
  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush && !ev_tx_ovf && !ev_tx_udf |=> !status[13] && !status[14]); // R9
  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en & IRQ_MASK) == '0 |-> !irq); // R10
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == 1'b0 && status[15] == 1'b0 && status[30:18] == '0); // R11
endmodule

// File: tb/spi_irq_status_tb.sv
module spi_irq_status_tb;
  localparam int PERIOD = 10;
  localparam int D = 64;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] tx_used = 0, rx_used = 0;
  logic tx_flush = 0, rx_flush = 0;
  logic ev_tx_ovf = 0, ev_tx_udf = 0, ev_rx_ovf = 0, ev_rx_udf = 0;
  logic ev_done = 0, ev_cs = 0, ev_fault = 0, clr_en = 0;
  logic [31:0] clr_data = 0, irq_en = 0;
  logic [31:0] status;
  logic irq;

  int checks = 0, fails = 0;
  logic [31:0] m_sticky = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_irq_status #(.DEPTH(D)) u_dut (.*);

  function automatic logic [31:0] exp_lvl(int rx, int tx);
    logic [31:0] v = 0;
    v[0] = rx != 0;       v[3] = rx >= D/4;    v[1] = rx >= D/2;
    v[4] = (D - rx) <= D/4; v[2] = rx == D;
    v[8] = tx == 0;       v[11] = (D - tx) >= D/4; v[9] = (D - tx) >= D/2;
    v[12] = tx <= D/4;    v[10] = tx == D;
    return v;
  endfunction

  function automatic logic [31:0] ev_vec();
    logic [31:0] v = 0;
    v[5] = ev_rx_ovf; v[6] = ev_rx_udf; v[13] = ev_tx_ovf; v[14] = ev_tx_udf;
    v[16] = ev_done;  v[17] = ev_cs;    v[31] = ev_fault;
    return v;
  endfunction

  function automatic logic [31:0] next_sticky(logic [31:0] cur);
    logic [31:0] c = 0;
    if (clr_en) c |= clr_data & 32'h0003_6060;
    if (tx_flush) c |= 32'h6000;
    if (rx_flush) c |= 32'h60;
    return (cur & ~c) | ev_vec();
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] e;
    e = m_sticky | exp_lvl(int'(rx_used), int'(tx_used));
    chk("R2", status & 32'h1F, e & 32'h1F);
    chk("R3", status & 32'h1F00, e & 32'h1F00);
    chk("R5/R6/R9", status & 32'h8003_6060, m_sticky);
    chk("R11", status & 32'h7FFC_8080, 32'h0);
    chk("R10", {31'b0, irq}, {31'b0, |(e & irq_en & 32'h0003_7F7F)});
  endtask

  task automatic clear_pulses();
    tx_flush = 0; rx_flush = 0; ev_tx_ovf = 0; ev_tx_udf = 0; ev_rx_ovf = 0;
    ev_rx_udf = 0; ev_done = 0; ev_cs = 0; ev_fault = 0; clr_en = 0; clr_data = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    m_sticky = next_sticky(m_sticky);
    @(negedge clk);
    clear_pulses();
    #1;
  endtask

  function automatic logic [CW-1:0] pick_count();
    int c[13] = '{0, 1, 15, 16, 17, 31, 32, 33, 47, 48, 49, 63, 64};
    if ($urandom % 2) return CW'(c[$urandom % 13]);
    return CW'($urandom % (D + 1));
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(PERIOD * 3);
    @(negedge clk); #1;
    chk("R1", status, 32'h0000_1B00);
    chk("R1", {31'b0, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", status, 32'h0000_1B00);

    // R4: clear of level bits has no effect
    rx_used = 40; tx_used = 64; #1;
    chk("R4", status, exp_lvl(40, 64));
    clr_en = 1; clr_data = 32'hFFFF_FFFF;
    tick();
    chk("R4", status, exp_lvl(40, 64));

    // R5: all events set
    ev_rx_ovf = 1; ev_rx_udf = 1; ev_tx_ovf = 1; ev_tx_udf = 1;
    ev_done = 1; ev_cs = 1; ev_fault = 1;
    tick();
    chk("R5", status & 32'h8003_6060, 32'h8003_6060);

    // R7: fault bit survives full clear
    clr_en = 1; clr_data = 32'hFFFF_FFFF;
    tick();
    chk("R7", status & 32'h8003_6060, 32'h8000_0000);

    // R8: set wins over clear
    ev_done = 1; clr_en = 1; clr_data = 32'h0001_0000;
    tick();
    chk("R8", {31'b0, status[16]}, 32'h1);

    // R9: flushes clear only their bits
    ev_rx_ovf = 1; ev_rx_udf = 1; ev_tx_ovf = 1; ev_tx_udf = 1; ev_cs = 1;
    tick();
    tx_flush = 1;
    tick();
    chk("R9", status & 32'h0003_6060, 32'h0003_0060);
    rx_flush = 1;
    tick();
    chk("R9", status & 32'h0003_6060, 32'h0003_0000);

    // R10: fault bit and out-of-mask enables never raise irq
    rx_used = 0; tx_used = 40; #1;
    irq_en = 32'h8000_8080 | 32'h0000_0100; #1;
    chk("R10", {31'b0, irq}, 32'h0);
    irq_en = 32'h0001_0000; #1;
    chk("R10", {31'b0, irq}, 32'h1);
    clr_en = 1; clr_data = 32'h0001_0000;
    tick();
    chk("R10", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      rx_used = pick_count(); tx_used = pick_count();
      irq_en = $urandom;
      ev_rx_ovf = ($urandom % 8) == 0; ev_rx_udf = ($urandom % 8) == 0;
      ev_tx_ovf = ($urandom % 8) == 0; ev_tx_udf = ($urandom % 8) == 0;
      ev_done = ($urandom % 8) == 0;   ev_cs = ($urandom % 8) == 0;
      ev_fault = ($urandom % 200) == 0;
      tx_flush = ($urandom % 10) == 0; rx_flush = ($urandom % 10) == 0;
      clr_en = ($urandom % 4) == 0;    clr_data = $urandom;
      #1;
      check_all();
      tick();
    end
    check_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule